// File: doc/BRIEF.md
# Single-Bit Clock-Crossing Synchronizer with Hold-Time Monitor

This block brings one level signal, launched from a register in a clock domain that has no known frequency or phase relation to the local clock, into the destination domain. The signal passes through a chain of two destination-clock flops. Nothing combinational sits in the path.

A monitor runs alongside the synchronizer on the destination clock. It keeps its own registered samples of the input and tracks how many destination edges each new value survives. A value must be seen on at least three consecutive edges to be carried across reliably. When a value is replaced after only one or two samples, the monitor raises a sticky error flag.

The monitor state machine has three states:

- `MS_SETTLED`: the current value has been held for three or more samples.
- `MS_FRESH`: a change has just been seen, and the new value has one sample.
- `MS_SECOND`: the new value has two samples.

The transitions are:

- `MS_SETTLED` to `MS_FRESH` on a change.
- `MS_FRESH` to `MS_SECOND` on no change.
- `MS_FRESH` to `MS_FRESH` on a change. This raises the narrow-pulse flag.
- `MS_SECOND` to `MS_SETTLED` on no change.
- `MS_SECOND` to `MS_FRESH` on a change. This raises the short-hold flag.

Software or a supervising block clears both flags with a one-cycle clear pulse.

Top module: `cdc_bit_guard`

## Requirements
- R1: A value captured from `async_in` at destination edge k appears on `sync_out` after edge k+1. It passes through exactly two flops with no logic between them.
- R2: While `rst_dst_n` is low, `sync_out`, `err_short` and `err_hold` are 0 and the monitor state is `MS_SETTLED`. The reset takes effect without a clock edge. The reset value 0 counts as a settled value.
- R3: A value that is sampled on three or more consecutive edges raises neither flag.
- R4: If a value is first captured at edge k and a different value is captured at edge k+1, `err_short` is 1 after edge k+2.
- R5: If a value is captured at edges k and k+1 and a different value is captured at edge k+2, `err_hold` is 1 after edge k+3.
- R6: Once set, each flag stays at 1 until `err_clr` is sampled high.
- R7: `err_clr` sampled high at an edge clears both flags after that edge. The exception is a flag whose error is detected at the same edge: that flag is 1.
- R8: The two flags are independent. A one-sample value never sets `err_hold`, and a two-sample value never sets `err_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dst | input | 1 | Destination clock |
| rst_dst_n | input | 1 | Active-low asynchronous reset |
| async_in | input | 1 | Level input from an unrelated clock domain |
| err_clr | input | 1 | Synchronous clear for both error flags |
| sync_out | output | 1 | Synchronized copy of the input |
| err_short | output | 1 | Sticky flag: a value lasted one sample |
| err_hold | output | 1 | Sticky flag: a value lasted two samples |

## Verification
The assertions assume that `async_in` has one defined value at each destination edge. Their history terms use `$past` of the input as the sample sequence. They also assume the reset has been released for a few edges before a flag may rise.

The bench changes `async_in` and `err_clr` only on the falling edge, so every rising edge captures a well-defined value. It keeps both low throughout reset.

Random run lengths of one to five samples, together with directed one-, two- and three-sample pulses, exercise every monitor transition. Occasional clear pulses land on edges that also set a flag.

// File: rtl/cdc_bit_guard_pkg.sv
package cdc_bit_guard_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        MS_SETTLED = 2'd0,
        MS_FRESH   = 2'd1,
        MS_SECOND  = 2'd2
    } mon_state_e;

endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
    parameter int   DEPTH     = 2,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic first_o,
    output logic dout
);

    logic [DEPTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {DEPTH{RST_LEVEL}};
        end else begin
            stg_q <= {stg_q[DEPTH-2:0], din};
        end
    end

    assign first_o = stg_q[0];
    assign dout    = stg_q[DEPTH-1];

endmodule

// File: rtl/cdc_bit_monitor.sv
module cdc_bit_monitor
    import cdc_bit_guard_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic copy_o,
    output logic short_o,
    output logic hold_o
);

    logic       samp_q;
    logic       prev_q;
    logic       chg;
    logic       set_short;
    logic       set_hold;
    logic       short_q;
    logic       hold_q;
    mon_state_e st_q;
    mon_state_e st_d;

    // private sample pair, separate from the synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= RST_LEVEL;
            prev_q <= RST_LEVEL;
        end else begin
            samp_q <= din;
            prev_q <= samp_q;
        end
    end

    assign chg = samp_q ^ prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MS_SETTLED;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and error detection
    always_comb begin
        st_d      = st_q;
        set_short = 1'b0;
        set_hold  = 1'b0;
        unique case (st_q)
            MS_SETTLED: begin
                if (chg) st_d = MS_FRESH;
            end
            MS_FRESH: begin
                if (chg) begin
                    set_short = 1'b1;
                    st_d      = MS_FRESH;
                end else begin
                    st_d = MS_SECOND;
                end
            end
            MS_SECOND: begin
                if (chg) begin
                    set_hold = 1'b1;
                    st_d     = MS_FRESH;
                end else begin
                    st_d = MS_SETTLED;
                end
            end
            default: st_d = MS_SETTLED;
        endcase
    end

    // sticky flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            short_q <= set_short | (short_q & ~clr);
            hold_q  <= set_hold  | (hold_q  & ~clr);
        end
    end

    assign copy_o  = samp_q;
    assign short_o = short_q;
    assign hold_o  = hold_q;

    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        short_o && !clr |=> short_o);   // R6
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o && !clr |=> hold_o);   // R6
    AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4)
        && $rose(short_o)
        |-> ($past(din, 2) != $past(din, 3)) && ($past(din, 3) != $past(din, 4)));   // R4
    AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4)
        && $past(rst_n, 5) && $rose(hold_o)
        |-> ($past(din, 2) != $past(din, 3)) && ($past(din, 3) == $past(din, 4))
            && ($past(din, 4) != $past(din, 5)));   // R5
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'd3);   // R2

endmodule

// File: rtl/cdc_bit_guard.sv
module cdc_bit_guard
    import cdc_bit_guard_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk_dst,
    input  logic rst_dst_n,
    input  logic async_in,
    input  logic err_clr,
    output logic sync_out,
    output logic err_short,
    output logic err_hold
);

    logic sync_first;
    logic mon_copy;

    cdc_bit_sync #(
        .DEPTH     (SYNC_DEPTH),
        .RST_LEVEL (RST_LEVEL)
    ) u_sync (
        .clk     (clk_dst),
        .rst_n   (rst_dst_n),
        .din     (async_in),
        .first_o (sync_first),
        .dout    (sync_out)
    );

    cdc_bit_monitor #(
        .RST_LEVEL (RST_LEVEL)
    ) u_mon (
        .clk     (clk_dst),
        .rst_n   (rst_dst_n),
        .din     (async_in),
        .clr     (err_clr),
        .copy_o  (mon_copy),
        .short_o (err_short),
        .hold_o  (err_hold)
    );

    AST_COPY_MATCH: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
        sync_first == mon_copy);   // R1
    AST_OUT_LAG: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
        $past(rst_dst_n, 1) && $past(rst_dst_n, 2) |-> sync_out == $past(async_in, 2));   // R1

endmodule

// File: tb/cdc_bit_guard_bench.sv
module cdc_bit_guard_bench;

    logic clk_dst = 1'b0;
    logic rst_dst_n = 1'b0;
    logic async_in = 1'b0;
    logic err_clr = 1'b0;
    logic sync_out;
    logic err_short;
    logic err_hold;

    int n_checks = 0;
    int n_fail = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic m_run_val;
    int   m_run_len;
    logic m_last;
    logic e_dout, e_short, e_hold, p_short, p_hold;

    always #10 clk_dst = ~clk_dst;

    cdc_bit_guard u_cdc_bit_guard (
        .clk_dst   (clk_dst),
        .rst_dst_n (rst_dst_n),
        .async_in  (async_in),
        .err_clr   (err_clr),
        .sync_out  (sync_out),
        .err_short (err_short),
        .err_hold  (err_hold)
    );

    function automatic logic next_flag(logic cur, logic clr, logic pend);
        return pend | (cur & ~clr);
    endfunction

    always @(posedge clk_dst or negedge rst_dst_n) begin
        if (!rst_dst_n) begin
            m_run_val = 1'b0;
            m_run_len = 3;
            m_last    = 1'b0;
            e_dout    = 1'b0;
            e_short   = 1'b0;
            e_hold    = 1'b0;
            p_short   = 1'b0;
            p_hold    = 1'b0;
        end else begin
            e_dout  = m_last;
            e_short = next_flag(e_short, err_clr, p_short);
            e_hold  = next_flag(e_hold, err_clr, p_hold);
            p_short = 1'b0;
            p_hold  = 1'b0;
            if (async_in != m_run_val) begin
                if (m_run_len == 1) p_short = 1'b1;
                else if (m_run_len == 2) p_hold = 1'b1;
                m_run_val = async_in;
                m_run_len = 1;
            end else if (m_run_len < 3) begin
                m_run_len = m_run_len + 1;
            end
            m_last = async_in;
        end
    end

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk_dst) begin
        if (running && rst_dst_n) begin
            check_bit("R1 sync_out", sync_out, e_dout);
            check_bit("R4 err_short", err_short, e_short);
            check_bit("R5 err_hold", err_hold, e_hold);
        end
    end

    task automatic drive(logic v, logic c);
        @(negedge clk_dst);
        async_in = v;
        err_clr  = c;
    endtask

    task automatic hold_for(logic v, int n);
        for (int i = 0; i < n; i++) drive(v, 1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int unsigned seed_dummy;
        logic v;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk_dst);
        // R2: reset values
        check_bit("R2 sync_out", sync_out, 1'b0);
        check_bit("R2 err_short", err_short, 1'b0);
        check_bit("R2 err_hold", err_hold, 1'b0);
        rst_dst_n = 1'b1;
        running = 1'b1;
        hold_for(1'b0, 5);

        // R4 and R8: one-sample pulse
        drive(1'b1, 1'b0);
        hold_for(1'b0, 6);
        @(negedge clk_dst);
        check_bit("R4 short after pulse", err_short, 1'b1);
        check_bit("R8 hold untouched", err_hold, 1'b0);

        // R7: plain clear
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk_dst);
        check_bit("R7 short cleared", err_short, 1'b0);

        // R5 and R8: two-sample pulse
        hold_for(1'b1, 2);
        hold_for(1'b0, 6);
        @(negedge clk_dst);
        check_bit("R5 hold after pulse", err_hold, 1'b1);
        check_bit("R8 short untouched", err_short, 1'b0);

        // R6: stays set over a long quiet stretch
        hold_for(1'b0, 20);
        @(negedge clk_dst);
        check_bit("R6 hold sticky", err_hold, 1'b1);

        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);

        // R3: three-sample pulse, no error
        hold_for(1'b1, 3);
        hold_for(1'b0, 6);
        @(negedge clk_dst);
        check_bit("R3 no short", err_short, 1'b0);
        check_bit("R3 no hold", err_hold, 1'b0);

        // R7: set hold, then clear on the edge a new short error is detected
        hold_for(1'b1, 2);
        hold_for(1'b0, 4);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        @(negedge clk_dst);
        check_bit("R7 set wins over clear", err_short, 1'b1);
        check_bit("R7 hold cleared", err_hold, 1'b0);
        async_in = 1'b0;
        err_clr  = 1'b0;
        hold_for(1'b0, 4);

        // random runs with occasional clears
        v = 1'b1;
        for (int r = 0; r < 600; r++) begin
            int len;
            len = 1 + int'($urandom % 5);
            for (int i = 0; i < len; i++) begin
                drive(v, ($urandom % 8) == 0);
            end
            v = ~v;
        end
        hold_for(1'b0, 6);
        @(negedge clk_dst);
        running = 1'b0;
        done = 1'b1;
        finish_run();
    end

endmodule